// File: doc/BRIEF.md
# Toggle-Mode Write Pulse Sequencer

This block runs one write cycle into a magnetic memory word of 16 bits, laid out as four sub-arrays that each hold four bits. In toggle operation a cell flips its state each time it receives a word-line pulse followed by a bit-line pulse. It cannot be driven directly to 0 or 1. So the sequencer first fetches the stored word through a read port and XORs it with the incoming data. It then pulses only the bits that must flip, and only the word lines of sub-arrays that hold such a bit.

In conventional operation, selected by a mode input, there is no pre-read. Every bit and every word line is pulsed, and a per-bit polarity output carries the data value, which sets the bit-line current direction. In toggle operation the polarity stays at a single fixed direction.

Pulse timing is set in clock cycles:
- the word-line pulse width;
- the bit-line pulse width;
- the lag from the word-line rising edge to the bit-line rising edge.

The bit-line pulse is clipped so that it never outlasts the word-line pulse. A one-cycle done pulse closes every write, and busy covers the whole cycle.

Top module: `mram_toggle_wctl`

## Requirements
- R1: After reset, rd_req, busy, done, every word-line enable, every bit-line enable and every polarity bit are low.
- R2: In toggle mode (toggle_mode=1) exactly one read is requested, with rd_addr equal to the write address, before any pulse. In conventional mode (toggle_mode=0) no read is requested.
- R3: In toggle mode, bit i receives a bit-line pulse only when bit i of rd_data differs from bit i of the write data. After the write the word equals the write data whenever the bit-line window is non-empty.
- R4: Let the effective lag d be bl_lag, with 0 counted as 1, and let the effective word-line width be w. Each bit-line pulse rises d cycles after the word-line rises. It lasts min(b, w-d) cycles, or none if d >= w, where b is bl_cycles with 0 counted as 1.
- R5: Every issued word-line pulse lasts exactly wl_cycles cycles, with 0 counted as 1.
- R6: Sub-array s owns data bits 4s to 4s+3 and word-line enable bit s. Its word line is pulsed only when at least one of its bits is selected.
- R7: In toggle mode bl_pol is all zero. In conventional mode, while bit i pulses, bl_pol[i] equals write data bit i.
- R8: In conventional mode all 16 bit lines and all 4 word lines are pulsed, and the word then equals the write data whenever the bit-line window is non-empty.
- R9: rd_req is low in every cycle in which any word-line or bit-line enable is high.
- R10: In toggle mode, if the read word equals the write data, no pulse is issued and done rises in the cycle after the read response is taken.
- R11: done is a one-cycle pulse that coincides with busy falling. After a pulse sequence, done rises the cycle after the last word-line cycle. A write request made while busy is ignored.
- R12: A bit-line enable is never high unless the word-line enable of its sub-array is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, taken when idle |
| wr_addr | input | AW | Word address |
| wr_data | input | 16 | Data to write |
| toggle_mode | input | 1 | 1 = toggle with pre-read, 0 = conventional |
| wl_cycles | input | CW | Word-line pulse width in cycles (0 as 1) |
| bl_cycles | input | CW | Bit-line pulse width in cycles (0 as 1) |
| bl_lag | input | CW | Word-line to bit-line rising lag (0 as 1) |
| rd_req | output | 1 | Pre-read request, held until rd_valid |
| rd_addr | output | AW | Pre-read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 16 | Stored word returned by the read |
| wl_en | output | 4 | Per-sub-array word-line pulse enable |
| bl_en | output | 16 | Per-bit bit-line pulse enable |
| bl_pol | output | 16 | Per-bit bit-line current direction |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
If the latched difference mask is wrong, the wrong bits flip in the bench's cell model. That shows up in the pulse pattern and in the stored word as soon as the write ends. A timing counter that is off by one moves the bit-line rising edge, the pulse length or the done cycle by one cycle, so the first affected write exposes it. A stuck sequencer state shows as a missing done or a read overlapping a pulse within one write cycle.

// File: rtl/mram_twc_pkg.sv
package mram_twc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_PULSE = 2'd2
  } wstate_t;
endpackage

// File: rtl/mram_twc_sel.sv
module mram_twc_sel #(
  parameter int SUBS = 4,
  parameter int BPS  = 4,
  localparam int W   = SUBS * BPS
) (
  input  logic [W-1:0]    stored,
  input  logic [W-1:0]    wdata,
  input  logic            conv,
  output logic [W-1:0]    bit_sel,
  output logic [SUBS-1:0] sub_sel
);
  // conventional writes drive every cell; toggle writes only flip differing cells
  assign bit_sel = conv ? {W{1'b1}} : (stored ^ wdata);

  for (genvar s = 0; s < SUBS; s++) begin : g_sub
    assign sub_sel[s] = |bit_sel[s*BPS +: BPS];
  end
endmodule

// File: rtl/mram_twc_timer.sv
module mram_twc_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] wl_len,
  input  logic [CW-1:0] bl_len,
  input  logic [CW-1:0] lag,
  output logic          wl_act,
  output logic          bl_act,
  output logic          last
);
  logic          run;
  logic [CW:0]   cnt, nxt, wlw_q, d_q, e_q;

  function automatic logic [CW:0] eff(input logic [CW-1:0] v);
    return (v == '0) ? (CW+1)'(1) : {1'b0, v};
  endfunction

  assign nxt  = cnt + 1'b1;
  assign last = run && (nxt == wlw_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      cnt    <= '0;
      wlw_q  <= '0;
      d_q    <= '0;
      e_q    <= '0;
      wl_act <= 1'b0;
      bl_act <= 1'b0;
    end else if (start) begin
      run    <= 1'b1;
      cnt    <= '0;
      wlw_q  <= eff(wl_len);
      d_q    <= eff(lag);
      e_q    <= eff(lag) + eff(bl_len);
      wl_act <= 1'b1;
      bl_act <= 1'b0;
    end else if (run) begin
      if (last) begin
        run    <= 1'b0;
        wl_act <= 1'b0;
        bl_act <= 1'b0;
      end else begin
        cnt    <= nxt;
        bl_act <= (nxt >= d_q) && (nxt < e_q);
      end
    end
  end

  // R12: bit-line window is nested inside the word-line window
  a_r12_bl_nested: assert property (@(posedge clk) disable iff (rst)
    bl_act |-> wl_act);
  // R4: the bit-line never starts together with the word-line
  a_r4_wl_first: assert property (@(posedge clk) disable iff (rst)
    $rose(wl_act) |-> !bl_act);
endmodule

// File: rtl/mram_toggle_wctl.sv
module mram_toggle_wctl #(
  parameter int SUBS = 4,
  parameter int BPS  = 4,
  parameter int AW   = 4,
  parameter int CW   = 5,
  localparam int W   = SUBS * BPS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            toggle_mode,
  input  logic [CW-1:0]   wl_cycles,
  input  logic [CW-1:0]   bl_cycles,
  input  logic [CW-1:0]   bl_lag,
  output logic            rd_req,
  output logic [AW-1:0]   rd_addr,
  input  logic            rd_valid,
  input  logic [W-1:0]    rd_data,
  output logic [SUBS-1:0] wl_en,
  output logic [W-1:0]    bl_en,
  output logic [W-1:0]    bl_pol,
  output logic            busy,
  output logic            done
);
  import mram_twc_pkg::*;

  wstate_t         st;
  logic [AW-1:0]   addr_q;
  logic [W-1:0]    data_q, bsel_q;
  logic [SUBS-1:0] ssel_q;
  logic            conv_q, done_q;
  logic [W-1:0]    cmp_bits;
  logic [SUBS-1:0] cmp_subs;
  logic            idle_take, rd_take, t_start, t_wl, t_bl, t_last;

  assign idle_take = (st == ST_IDLE) && wr_req;
  assign rd_take   = (st == ST_READ) && rd_valid;
  assign t_start   = (idle_take && !toggle_mode) || (rd_take && (cmp_bits != '0));

  mram_twc_sel #(.SUBS(SUBS), .BPS(BPS)) u_sel (
    .stored  (rd_data),
    .wdata   ((st == ST_IDLE) ? wr_data : data_q),
    .conv    ((st == ST_IDLE) ? !toggle_mode : conv_q),
    .bit_sel (cmp_bits),
    .sub_sel (cmp_subs)
  );

  mram_twc_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (t_start),
    .wl_len (wl_cycles),
    .bl_len (bl_cycles),
    .lag    (bl_lag),
    .wl_act (t_wl),
    .bl_act (t_bl),
    .last   (t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      bsel_q <= '0;
      ssel_q <= '0;
      conv_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (wr_req) begin
          addr_q <= wr_addr;
          data_q <= wr_data;
          conv_q <= !toggle_mode;
          if (!toggle_mode) begin
            bsel_q <= cmp_bits;
            ssel_q <= cmp_subs;
            st     <= ST_PULSE;
          end else begin
            st     <= ST_READ;
          end
        end
        ST_READ: if (rd_valid) begin
          if (cmp_bits == '0) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            bsel_q <= cmp_bits;
            ssel_q <= cmp_subs;
            st     <= ST_PULSE;
          end
        end
        ST_PULSE: if (t_last) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = (st == ST_READ);
  assign rd_addr = addr_q;
  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign wl_en   = t_wl ? ssel_q : '0;
  assign bl_en   = t_bl ? bsel_q : '0;
  assign bl_pol  = (t_bl && conv_q) ? data_q : '0;

  // R9: no read request while current pulses are applied
  a_r9_no_read_in_pulse: assert property (@(posedge clk) disable iff (rst)
    ((wl_en != '0) || (bl_en != '0)) |-> !rd_req);
  // R7: toggle writes use a single bit-line direction
  a_r7_single_dir: assert property (@(posedge clk) disable iff (rst)
    !conv_q |-> (bl_pol == '0));
  // R11: done coincides with idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R10: identical word ends the cycle right after the read
  a_r10_skip_pulses: assert property (@(posedge clk) disable iff (rst)
    (rd_take && (cmp_bits == '0)) |=> (done && (wl_en == '0)));
  // R2: a toggle pulse sequence always follows a read
  a_r2_read_first: assert property (@(posedge clk) disable iff (rst)
    ($rose(t_wl) && !conv_q) |-> $past(st == ST_READ));

  for (genvar s = 0; s < SUBS; s++) begin : g_chk
    // R12: bit lines of a sub-array only inside its own word-line pulse
    a_r12_sub_wl: assert property (@(posedge clk) disable iff (rst)
      (bl_en[s*BPS +: BPS] != '0) |-> wl_en[s]);
  end
endmodule

// File: tb/test_mram_toggle_wctl.sv
module test_mram_toggle_wctl;
  localparam int CLK_PERIOD = 10;
  localparam int SUBS = 4, BPS = 4, W = 16, AW = 4, CW = 5;

  logic            clk = 1'b0, rst = 1'b1;
  logic            wr_req = 1'b0, toggle_mode = 1'b1, rd_valid = 1'b0;
  logic [AW-1:0]   wr_addr = '0, rd_addr;
  logic [W-1:0]    wr_data = '0, rd_data = '0, bl_en, bl_pol;
  logic [CW-1:0]   wl_cycles = '0, bl_cycles = '0, bl_lag = '0;
  logic            rd_req, busy, done;
  logic [SUBS-1:0] wl_en;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] mem [2**AW];

  mram_toggle_wctl #(.SUBS(SUBS), .BPS(BPS), .AW(AW), .CW(CW)) i_mram_toggle_wctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int bl_len_exp(input int wl, input int bl, input int dl);
    int w = eff(wl), d = eff(dl), b = eff(bl);
    if (d >= w) return 0;
    return (b < w - d) ? b : (w - d);
  endfunction

  function automatic logic [SUBS-1:0] sub_of(input logic [W-1:0] m);
    logic [SUBS-1:0] r;
    for (int s = 0; s < SUBS; s++) r[s] = |m[s*BPS +: BPS];
    return r;
  endfunction

  task automatic run_write(input logic [AW-1:0] a, input logic [W-1:0] d, input bit tog,
                           input int wl, input int bl, input int dl, input int lat, input bit inject);
    logic [W-1:0] old = mem[a];
    logic [W-1:0] mask = tog ? (old ^ d) : {W{1'b1}};
    int wlw = eff(wl), dd = eff(dl), blc = bl_len_exp(wl, bl, dl);
    int wl_cnt [SUBS], bl_cnt [W], bl_first [W];
    int wl_first = -1, resp_cyc = -1, done_cyc = -1, reads = 0, lat_left = lat;
    int exp_first, exp_done, bad_len = 0, bad_bl = 0;
    bit prev_rq = 0, addr_bad = 0, bl_wo_wl = 0, busy_at_done = 1;
    logic [W-1:0] pol_v = '0, bl_pat = '0, exp_bl;
    logic [SUBS-1:0] wl_pat = '0;
    for (int s = 0; s < SUBS; s++) wl_cnt[s] = 0;
    for (int i = 0; i < W; i++) begin bl_cnt[i] = 0; bl_first[i] = -1; end

    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d; toggle_mode = tog;
    wl_cycles = CW'(wl); bl_cycles = CW'(bl); bl_lag = CW'(dl);
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      wr_req = (inject && cyc == 2);
      if (inject) begin wr_addr = ~a; wr_data = ~d; end
      rd_valid = 1'b0;
      if (rd_req && !prev_rq) begin reads++; if (rd_addr != a) addr_bad = 1; end
      prev_rq = rd_req;
      for (int s = 0; s < SUBS; s++)
        if (wl_en[s]) begin wl_cnt[s]++; if (wl_first < 0) wl_first = cyc; end
      for (int i = 0; i < W; i++)
        if (bl_en[i]) begin
          bl_cnt[i]++;
          if (bl_first[i] < 0) bl_first[i] = cyc;
          pol_v[i] = bl_pol[i];
          if (!wl_en[i/BPS]) bl_wo_wl = 1;
          if (rd_req) bl_wo_wl = 1;
        end
      if (wl_en != '0 && rd_req) addr_bad = 1;
      if (rd_req && resp_cyc < 0) begin
        if (lat_left == 0) begin rd_valid = 1'b1; rd_data = mem[rd_addr]; resp_cyc = cyc; end
        else lat_left--;
      end
      if (done) begin done_cyc = cyc; busy_at_done = busy; break; end
    end
    wr_req = 1'b0;

    if (done_cyc < 0) chk(0, "R11 write never completed", 0, 1);
    for (int s = 0; s < SUBS; s++) begin
      wl_pat[s] = wl_cnt[s] > 0;
      if (wl_cnt[s] > 0 && wl_cnt[s] != wlw) bad_len++;
    end
    for (int i = 0; i < W; i++) begin
      bl_pat[i] = bl_cnt[i] > 0;
      if (bl_cnt[i] > 0 && (bl_cnt[i] != blc || bl_first[i] != wl_first + dd)) bad_bl++;
    end
    exp_bl    = (blc > 0) ? mask : '0;
    exp_first = tog ? resp_cyc + 1 : 0;
    exp_done  = (mask != '0) ? exp_first + wlw : resp_cyc + 1;

    chk(tog ? (reads == 1 && !addr_bad) : (reads == 0 && !addr_bad), "R2 pre-read count/addr (R9)", reads, tog);
    chk(bl_pat == exp_bl, tog ? "R3 bit-line pattern" : "R8 bit-line pattern", bl_pat, exp_bl);
    chk(wl_pat == sub_of(mask), "R6 word-line pattern", wl_pat, sub_of(mask));
    chk(bad_len == 0, "R5 word-line width", bad_len, 0);
    chk(bad_bl == 0 && !bl_wo_wl, "R4 bit-line lag/width (R12)", bad_bl, 0);
    if (mask != '0) chk(wl_first == exp_first, "R4 word-line start", wl_first, exp_first);
    chk(tog ? (pol_v == '0) : ((pol_v & bl_pat) == (d & bl_pat)), "R7 polarity", pol_v, tog ? 0 : d);
    if (tog && mask == '0) chk(done_cyc == resp_cyc + 1 && wl_pat == '0, "R10 skip on equal word", done_cyc, resp_cyc + 1);
    chk(done_cyc == exp_done && !busy_at_done, "R11 done timing", done_cyc, exp_done);

    for (int i = 0; i < W; i++)
      if (bl_cnt[i] > 0) mem[a][i] = tog ? ~mem[a][i] : pol_v[i];
    chk(mem[a] == ((blc > 0) ? d : old), tog ? "R3 stored word" : "R8 stored word", mem[a], (blc > 0) ? d : old);

    @(negedge clk);
    chk(!done && !busy && wl_en == '0 && !rd_req, "R11 single done, stray request ignored", {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd4242);
    for (int i = 0; i < 2**AW; i++) mem[i] = W'($urandom);
    repeat (3) @(negedge clk);
    chk(!rd_req && !busy && !done && wl_en == '0 && bl_en == '0 && bl_pol == '0, "R1 reset outputs",
        {rd_req, busy, done, wl_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && wl_en == '0, "R1 idle after reset", busy, 0);

    // directed corners
    run_write(4'd1, mem[1], 1'b1, 6, 2, 2, 1, 1'b0);                 // R10 identical word
    run_write(4'd2, mem[2] ^ 16'h0020, 1'b1, 6, 3, 2, 0, 1'b0);      // R6 one sub only
    run_write(4'd3, 16'hA5C3, 1'b0, 8, 4, 3, 0, 1'b0);               // R8 conventional
    run_write(4'd4, ~mem[4], 1'b1, 0, 0, 0, 2, 1'b0);                // R5 zero lengths
    run_write(4'd5, ~mem[5], 1'b1, 4, 2, 4, 0, 1'b0);                // R4 lag beyond word-line
    run_write(4'd6, ~mem[6], 1'b1, 6, 9, 2, 0, 1'b0);                // R4 clipped bit-line
    run_write(4'd7, mem[7] ^ 16'h8001, 1'b1, 8, 3, 2, 1, 1'b1);      // R11 busy request ignored
    run_write(4'd8, 16'h0F0F, 1'b0, 1, 1, 1, 0, 1'b0);               // R4 conventional with empty window

    for (int n = 0; n < 70; n++) begin
      logic [AW-1:0] a = AW'($urandom);
      int sel = $urandom_range(0, 3);
      logic [W-1:0] d = (sel == 0) ? mem[a] : (sel == 1) ? (mem[a] ^ (16'h1 << $urandom_range(0, 15))) : W'($urandom);
      int wl = $urandom_range(2, 14);
      int dl = $urandom_range(0, wl - 1);
      int bl = $urandom_range(0, wl + 2);
      run_write(a, d, ($urandom_range(0, 3) != 0), wl, bl, dl, $urandom_range(0, 3), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule